// File: doc/BRIEF.md
# Radix-4 Butterfly Stage with Growing Width

This block is one pipelined stage of a radix-4 FFT datapath. Each accepted beat carries four complex fixed-point samples. Each sample first passes through its own twiddle multiplier. The block then forms the 4-point DFT of the four products with two rows of complex add/subtract.

A twiddle lane is one of two kinds, chosen at elaboration. An exact lane rotates by a whole quarter turn using only swaps and negations. A constant lane multiplies by a general fixed-point complex constant and rounds once, to a chosen number of fraction bits. No adder in the block ever rounds or wraps. Instead, each add row widens the data by one integer bit, so the output carries two more integer bits than the input.

Stages are chained to build larger transforms, with the data reordering done outside the block. One valid bit qualifies all four inputs and travels alongside the data.

Top module: `fft4_stage`

## Requirements
- R1: A beat accepted on a rising edge with `in_valid_i` high appears on the outputs after the 4th rising edge counted from the one that accepted it. At that point `out_valid_o` is high for exactly one cycle. `out_valid_o` is `in_valid_i` delayed by 4 edges.
- R2: An exact lane with quarter-turn code q first scales its input to MUL_FRAC fraction bits, which is exact. It then multiplies by 1 (q=0), -j (q=1), -1 (q=2) or +j (q=3), where -j maps (r,i) to (i,-r). Default: lane 0 uses q=0 and lane 2 uses q=1.
- R3: A constant lane with constant (cr, ci) at COEF_FRAC fraction bits computes re = xr*cr - xi*ci and im = xr*ci + xi*cr. It adds 2^(s-1) to each and shifts arithmetically right by s = IN_FRAC + COEF_FRAC - MUL_FRAC. Default constants: lane 1 uses (946, -392) and lane 3 uses (392, -946), with COEF_FRAC = 10.
- R4: With lane products t0..t3, the outputs are:
  - y0 = t0+t1+t2+t3
  - y1 = t0 - j t1 - t2 + j t3
  - y2 = t0 - t1 + t2 - t3
  - y3 = t0 + j t1 - t2 - j t3

  All of these are computed exactly.
- R5: Output lane k sits at index k of `out_re_o`/`out_im_o`. Each output has IN_W-IN_FRAC+2 integer bits and MUL_FRAC fraction bits, which is 12 bits with the defaults. The outputs never wrap for inputs allowed by R8.
- R6: Input data on cycles with `in_valid_i` low has no effect on any later output. The outputs hold their last value while `out_valid_o` is low.
- R7: While `rst_ni` is low, `out_valid_o` is low and all outputs are zero. A beat in flight when reset is asserted is discarded.
- R8: The caller keeps re^2 + im^2 below 2^(2(IN_W-1)) for every input sample on a valid beat, so that no sample reaches full-scale magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Qualifies all four input samples |
| in_re_i | input | 4 x IN_W | Real parts, lane k at index k, two's complement |
| in_im_i | input | 4 x IN_W | Imaginary parts |
| out_valid_o | output | 1 | Result beat present |
| out_re_o | output | 4 x (IN_W-IN_FRAC+MUL_FRAC+2) | Real parts of y0..y3 |
| out_im_o | output | 4 x (IN_W-IN_FRAC+MUL_FRAC+2) | Imaginary parts of y0..y3 |

## Verification
A beat driven before rising edge n leaves the twiddle lanes after edge n+1, the first add row after edge n+2 and the outputs after edge n+3. Counted from its own accepting edge, that is edge 4.

The bench drives and samples on falling edges. The iteration that drives beat t therefore compares beat t-4, and a lone pulse is expected to show `out_valid_o` high only on the fourth falling edge after it was driven. Hold checks sample one and more cycles after the last valid output, and the reset checks sample during the reset low phase and for the four cycles after release.

// File: rtl/fft4_pkg.sv
package fft4_pkg;
  localparam int LANES = 4;

  typedef enum logic {
    TW_EXACT = 1'b0,
    TW_CONST = 1'b1
  } tw_kind_e;

  // quarter-turn codes for exact lanes
  localparam logic [1:0] QT_ONE     = 2'd0;
  localparam logic [1:0] QT_NEG_J   = 2'd1;
  localparam logic [1:0] QT_NEG_ONE = 2'd2;
  localparam logic [1:0] QT_POS_J   = 2'd3;
endpackage

// File: rtl/fft4_twiddle.sv
module fft4_twiddle
  import fft4_pkg::*;
#(
  parameter int       IN_W      = 5,
  parameter int       IN_FRAC   = 4,
  parameter int       MUL_FRAC  = 9,
  parameter int       COEF_W    = 12,
  parameter int       COEF_FRAC = 10,
  parameter tw_kind_e KIND      = TW_EXACT,
  parameter int       QUARTER   = 0,
  parameter int       C_RE      = 0,
  parameter int       C_IM      = 0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               en_a_i,
  input  logic                               en_b_i,
  input  logic [IN_W-1:0]                    re_i,
  input  logic [IN_W-1:0]                    im_i,
  output logic [IN_W-IN_FRAC+MUL_FRAC-1:0]   re_o,
  output logic [IN_W-IN_FRAC+MUL_FRAC-1:0]   im_o
);
  localparam int M_W = IN_W - IN_FRAC + MUL_FRAC;

  if (KIND == TW_EXACT) begin : g_exact
    localparam int         PAD = MUL_FRAC - IN_FRAC;
    localparam logic [1:0] QT  = QUARTER[1:0];

    logic signed [M_W-1:0] xr, xi, rr, ri;
    logic signed [M_W-1:0] a_re, a_im;

    assign xr = M_W'($signed(re_i)) <<< PAD;
    assign xi = M_W'($signed(im_i)) <<< PAD;

    always_comb begin
      case (QT)
        QT_NEG_J:   begin rr = xi;  ri = -xr; end
        QT_NEG_ONE: begin rr = -xr; ri = -xi; end
        QT_POS_J:   begin rr = -xi; ri = xr;  end
        default:    begin rr = xr;  ri = xi;  end
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_re <= '0;
        a_im <= '0;
        re_o <= '0;
        im_o <= '0;
      end else begin
        if (en_a_i) begin
          a_re <= rr;
          a_im <= ri;
        end
        if (en_b_i) begin
          re_o <= a_re;
          im_o <= a_im;
        end
      end
    end
  end else begin : g_const
    localparam int P_W = IN_W + COEF_W;
    localparam int SH  = IN_FRAC + COEF_FRAC - MUL_FRAC;
    localparam logic signed [COEF_W-1:0] CR  = COEF_W'(C_RE);
    localparam logic signed [COEF_W-1:0] CI  = COEF_W'(C_IM);
    localparam logic signed [P_W:0]      RND = (P_W+1)'(1) <<< (SH - 1);

    logic signed [P_W-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [P_W:0]   s_re, s_im;

    // round once, after the exact sum of products
    assign s_re = (P_W+1)'(p_rr) - (P_W+1)'(p_ii) + RND;
    assign s_im = (P_W+1)'(p_ri) + (P_W+1)'(p_ir) + RND;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_rr <= '0;
        p_ii <= '0;
        p_ri <= '0;
        p_ir <= '0;
        re_o <= '0;
        im_o <= '0;
      end else begin
        if (en_a_i) begin
          p_rr <= $signed(re_i) * CR;
          p_ii <= $signed(im_i) * CI;
          p_ri <= $signed(re_i) * CI;
          p_ir <= $signed(im_i) * CR;
        end
        if (en_b_i) begin
          re_o <= M_W'(s_re >>> SH);
          im_o <= M_W'(s_im >>> SH);
        end
      end
    end
  end
endmodule

// File: rtl/fft4_bfly.sv
module fft4_bfly #(
  parameter int W       = 10,
  parameter bit NEG_J_B = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] a_re_i,
  input  logic [W-1:0] a_im_i,
  input  logic [W-1:0] b_re_i,
  input  logic [W-1:0] b_im_i,
  output logic [W:0]   sum_re_o,
  output logic [W:0]   sum_im_o,
  output logic [W:0]   dif_re_o,
  output logic [W:0]   dif_im_o
);
  logic signed [W:0] ar, ai, br, bi;

  assign ar = (W+1)'($signed(a_re_i));
  assign ai = (W+1)'($signed(a_im_i));

  if (NEG_J_B) begin : g_rot
    // b * (-j): swap, negate new imaginary part; extra bit absorbs the negation
    assign br = (W+1)'($signed(b_im_i));
    assign bi = -((W+1)'($signed(b_re_i)));
  end else begin : g_plain
    assign br = (W+1)'($signed(b_re_i));
    assign bi = (W+1)'($signed(b_im_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_o <= '0;
      sum_im_o <= '0;
      dif_re_o <= '0;
      dif_im_o <= '0;
    end else if (en_i) begin
      sum_re_o <= ar + br;
      sum_im_o <= ai + bi;
      dif_re_o <= ar - br;
      dif_im_o <= ai - bi;
    end
  end
endmodule

// File: rtl/fft4_stage.sv
module fft4_stage
  import fft4_pkg::*;
#(
  parameter int       IN_W                = 5,
  parameter int       IN_FRAC             = 4,
  parameter int       MUL_FRAC            = 9,
  parameter int       COEF_W              = 12,
  parameter int       COEF_FRAC           = 10,
  parameter tw_kind_e TW_KIND    [LANES]  = '{TW_EXACT, TW_CONST, TW_EXACT, TW_CONST},
  parameter int       TW_QUARTER [LANES]  = '{0, 0, 1, 0},
  parameter int       TW_RE      [LANES]  = '{0, 946, 0, 392},
  parameter int       TW_IM      [LANES]  = '{0, -392, 0, -946}
) (
  input  logic                                            clk_i,
  input  logic                                            rst_ni,
  input  logic                                            in_valid_i,
  input  logic [LANES-1:0][IN_W-1:0]                      in_re_i,
  input  logic [LANES-1:0][IN_W-1:0]                      in_im_i,
  output logic                                            out_valid_o,
  output logic [LANES-1:0][IN_W-IN_FRAC+MUL_FRAC+1:0]     out_re_o,
  output logic [LANES-1:0][IN_W-IN_FRAC+MUL_FRAC+1:0]     out_im_o
);
  localparam int M_W   = IN_W - IN_FRAC + MUL_FRAC;
  localparam int DEPTH = 4;  // 2 multiply levels + 2 add rows

  logic [DEPTH-1:0]            vld;
  logic [LANES-1:0][M_W-1:0]   tw_re, tw_im;
  logic [LANES-1:0][M_W:0]     r1_re, r1_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld <= '0;
    else         vld <= {vld[DEPTH-2:0], in_valid_i};
  end

  assign out_valid_o = vld[DEPTH-1];

  for (genvar l = 0; l < LANES; l++) begin : g_tw
    fft4_twiddle #(
      .IN_W      (IN_W),
      .IN_FRAC   (IN_FRAC),
      .MUL_FRAC  (MUL_FRAC),
      .COEF_W    (COEF_W),
      .COEF_FRAC (COEF_FRAC),
      .KIND      (TW_KIND[l]),
      .QUARTER   (TW_QUARTER[l]),
      .C_RE      (TW_RE[l]),
      .C_IM      (TW_IM[l])
    ) u_tw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_a_i (in_valid_i),
      .en_b_i (vld[0]),
      .re_i   (in_re_i[l]),
      .im_i   (in_im_i[l]),
      .re_o   (tw_re[l]),
      .im_o   (tw_im[l])
    );
  end

  // butterfly p writes sum to slot p, difference to slot p+2
  for (genvar p = 0; p < 2; p++) begin : g_row
    fft4_bfly #(.W(M_W), .NEG_J_B(1'b0)) u_r1 (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (vld[1]),
      .a_re_i   (tw_re[p]),
      .a_im_i   (tw_im[p]),
      .b_re_i   (tw_re[p+2]),
      .b_im_i   (tw_im[p+2]),
      .sum_re_o (r1_re[p]),
      .sum_im_o (r1_im[p]),
      .dif_re_o (r1_re[p+2]),
      .dif_im_o (r1_im[p+2])
    );

    fft4_bfly #(.W(M_W+1), .NEG_J_B(p == 1)) u_r2 (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (vld[2]),
      .a_re_i   (r1_re[2*p]),
      .a_im_i   (r1_im[2*p]),
      .b_re_i   (r1_re[2*p+1]),
      .b_im_i   (r1_im[2*p+1]),
      .sum_re_o (out_re_o[p]),
      .sum_im_o (out_im_o[p]),
      .dif_re_o (out_re_o[p+2]),
      .dif_im_o (out_im_o[p+2])
    );
  end
endmodule

// File: rtl/fft4_stage_chk.sv
module fft4_stage_chk
  import fft4_pkg::*;
#(
  parameter int       IN_W               = 5,
  parameter int       IN_FRAC            = 4,
  parameter int       MUL_FRAC           = 9,
  parameter tw_kind_e TW_KIND    [LANES] = '{TW_EXACT, TW_CONST, TW_EXACT, TW_CONST},
  parameter int       TW_QUARTER [LANES] = '{0, 0, 1, 0}
) (
  input logic                                        clk_i,
  input logic                                        rst_ni,
  input logic                                        in_valid_i,
  input logic [LANES-1:0][IN_W-1:0]                  in_re_i,
  input logic [LANES-1:0][IN_W-1:0]                  in_im_i,
  input logic                                        out_valid_o,
  input logic [LANES-1:0][IN_W-IN_FRAC+MUL_FRAC+1:0] out_re_o,
  input logic [LANES-1:0][IN_W-IN_FRAC+MUL_FRAC+1:0] out_im_o,
  input logic [LANES-1:0][IN_W-IN_FRAC+MUL_FRAC-1:0] tw_re_i,
  input logic [LANES-1:0][IN_W-IN_FRAC+MUL_FRAC-1:0] tw_im_i
);
  localparam int M_W = IN_W - IN_FRAC + MUL_FRAC;
  localparam int S_W = M_W + 4;
  localparam int PAD = MUL_FRAC - IN_FRAC;
  localparam int FS  = 1 << (2 * (IN_W - 1));

  logic [3:0]                 chk_v;
  logic [LANES-1:0][IN_W-1:0] in_re_d1, in_re_d2, in_im_d1, in_im_d2;
  logic [M_W-1:0]             t0_re_d1, t0_re_d2, t0_im_d1, t0_im_d2;
  logic signed [S_W-1:0]      sum_re, sum_im;
  logic                       mag_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v    <= '0;
      in_re_d1 <= '0;
      in_re_d2 <= '0;
      in_im_d1 <= '0;
      in_im_d2 <= '0;
      t0_re_d1 <= '0;
      t0_re_d2 <= '0;
      t0_im_d1 <= '0;
      t0_im_d2 <= '0;
    end else begin
      chk_v    <= {chk_v[2:0], in_valid_i};
      in_re_d1 <= in_re_i;
      in_re_d2 <= in_re_d1;
      in_im_d1 <= in_im_i;
      in_im_d2 <= in_im_d1;
      t0_re_d1 <= tw_re_i[0];
      t0_re_d2 <= t0_re_d1;
      t0_im_d1 <= tw_im_i[0];
      t0_im_d2 <= t0_im_d1;
    end
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    mag_ok = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      sum_re = sum_re + S_W'($signed(out_re_o[l]));
      sum_im = sum_im + S_W'($signed(out_im_o[l]));
      if (int'($signed(in_re_i[l])) * int'($signed(in_re_i[l])) +
          int'($signed(in_im_i[l])) * int'($signed(in_im_i[l])) >= FS)
        mag_ok = 1'b0;
    end
  end

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == chk_v[3]);

  // y0+y1+y2+y3 = 4*t0
  a_r4_sum_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sum_re == (S_W'($signed(t0_re_d2)) <<< 2));
  a_r4_sum_im: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sum_im == (S_W'($signed(t0_im_d2)) <<< 2));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(out_re_o) && $stable(out_im_o)));

  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> mag_ok);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r7_reset_clear: assert (!out_valid_o && out_re_o == '0 && out_im_o == '0);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (TW_KIND[l] == TW_EXACT) begin : g_exact
      localparam logic [1:0] QT = TW_QUARTER[l][1:0];
      logic signed [M_W-1:0] xr, xi, er, ei;
      assign xr = M_W'($signed(in_re_d2[l])) <<< PAD;
      assign xi = M_W'($signed(in_im_d2[l])) <<< PAD;
      always_comb begin
        er = xr;
        ei = xi;
        if (QT == QT_NEG_J)   begin er = xi;  ei = -xr; end
        if (QT == QT_NEG_ONE) begin er = -xr; ei = -xi; end
        if (QT == QT_POS_J)   begin er = -xi; ei = xr;  end
      end
      a_r2_exact_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_v[1] |-> ($signed(tw_re_i[l]) == er && $signed(tw_im_i[l]) == ei));
    end
  end
endmodule

bind fft4_stage fft4_stage_chk #(
  .IN_W       (IN_W),
  .IN_FRAC    (IN_FRAC),
  .MUL_FRAC   (MUL_FRAC),
  .TW_KIND    (TW_KIND),
  .TW_QUARTER (TW_QUARTER)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_re_i     (in_re_i),
  .in_im_i     (in_im_i),
  .out_valid_o (out_valid_o),
  .out_re_o    (out_re_o),
  .out_im_o    (out_im_o),
  .tw_re_i     (tw_re),
  .tw_im_i     (tw_im)
);

// File: tb/fft4_stage_test.sv
module fft4_stage_test;
  import fft4_pkg::*;

  localparam int IN_W      = 5;
  localparam int IN_FRAC   = 4;
  localparam int MUL_FRAC  = 9;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 10;
  localparam int O_W       = IN_W - IN_FRAC + MUL_FRAC + 2;
  localparam int PAD       = MUL_FRAC - IN_FRAC;
  localparam int SH        = IN_FRAC + COEF_FRAC - MUL_FRAC;
  localparam tw_kind_e B_KIND [4] = '{TW_EXACT, TW_CONST, TW_EXACT, TW_CONST};
  localparam int B_QT [4] = '{0, 0, 1, 0};
  localparam int B_RE [4] = '{0, 946, 0, 392};
  localparam int B_IM [4] = '{0, -392, 0, -946};

  // re0..re3, im0..im3
  localparam int NV = 12;
  localparam int VEC [NV][8] = '{
    '{  0,   0,   0,   0,    0,   0,   0,   0},
    '{  8,   0,   0,   0,    0,   0,   0,   0},
    '{  0,   8,   0,   0,    0,   0,   0,   0},
    '{  0,   0,   0,   5,    0,   0,   0,  -7},
    '{ 11,  11,  11,  11,   11,  11,  11,  11},
    '{-11, -11, -11, -11,  -11, -11, -11, -11},
    '{ 15, -15,  15, -15,    0,   0,   0,   0},
    '{  3,  -7,   9,  -2,   -5,   6,  -1,  10},
    '{  0,  15, -15,   0,   15,   0,   0, -15},
    '{ -9,   4,  13,  -6,    7, -12,   2,   8},
    '{  1,   1,   1,   1,   -1,  -1,  -1,  -1},
    '{ 15,   5, -15,  -5,    5, -15,  -5,  15}
  };

  logic                          clk;
  logic                          rst_n;
  logic                          in_valid;
  logic [3:0][IN_W-1:0]          in_re, in_im;
  logic                          out_valid;
  logic [3:0][O_W-1:0]           out_re, out_im;

  int total = 0;
  int bad   = 0;

  fft4_stage #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .MUL_FRAC(MUL_FRAC),
    .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .TW_KIND(B_KIND), .TW_QUARTER(B_QT), .TW_RE(B_RE), .TW_IM(B_IM)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .in_re_i(in_re), .in_im_i(in_im),
    .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int v[8], output int yr[4], output int yi[4]);
    int tr[4];
    int ti[4];
    for (int l = 0; l < 4; l++) begin
      int xr = v[l];
      int xi = v[l+4];
      if (B_KIND[l] == TW_EXACT) begin
        xr = xr * (1 << PAD);
        xi = xi * (1 << PAD);
        case (B_QT[l])
          1:       begin tr[l] = xi;  ti[l] = -xr; end
          2:       begin tr[l] = -xr; ti[l] = -xi; end
          3:       begin tr[l] = -xi; ti[l] = xr;  end
          default: begin tr[l] = xr;  ti[l] = xi;  end
        endcase
      end else begin
        tr[l] = (xr * B_RE[l] - xi * B_IM[l] + (1 << (SH - 1))) >>> SH;
        ti[l] = (xr * B_IM[l] + xi * B_RE[l] + (1 << (SH - 1))) >>> SH;
      end
    end
    yr[0] = tr[0] + tr[1] + tr[2] + tr[3];
    yi[0] = ti[0] + ti[1] + ti[2] + ti[3];
    yr[1] = tr[0] + ti[1] - tr[2] - ti[3];
    yi[1] = ti[0] - tr[1] - ti[2] + tr[3];
    yr[2] = tr[0] - tr[1] + tr[2] - tr[3];
    yi[2] = ti[0] - ti[1] + ti[2] - ti[3];
    yr[3] = tr[0] - ti[1] - tr[2] + ti[3];
    yi[3] = ti[0] + tr[1] - ti[2] - tr[3];
  endfunction

  task automatic drive(input int v[8], input logic vld);
    in_valid = vld;
    for (int l = 0; l < 4; l++) begin
      in_re[l] = IN_W'(v[l]);
      in_im[l] = IN_W'(v[l+4]);
    end
  endtask

  task automatic check_out(input string tag, input int v[8]);
    int yr[4];
    int yi[4];
    model(v, yr, yi);
    for (int l = 0; l < 4; l++) begin
      check_int(tag, int'($signed(out_re[l])), yr[l]);
      check_int(tag, int'($signed(out_im[l])), yi[l]);
    end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int junk[8];
    int last[8];
    rst_n = 1'b0;
    drive(VEC[0], 1'b0);
    repeat (3) @(negedge clk);

    // R7: reset state
    check_int("R7 reset valid", int'(out_valid), 0);
    check_int("R7 reset data", int'(out_re == '0 && out_im == '0), 1);
    // R5: output width
    check_int("R5 width", $bits(out_re[0]), 12);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: back-to-back stream
    for (int t = 0; t < NV + 4; t++) begin
      if (t >= 4) begin
        check_int("R1 stream valid", int'(out_valid), 1);
        check_out("R2 R3 R4 R5 stream", VEC[t-4]);
      end
      if (t < NV) drive(VEC[t], 1'b1);
      else        drive(VEC[0], 1'b0);
      @(negedge clk);
    end

    // R6: invalid junk ignored, outputs hold
    junk = '{-16, 7, -16, 3, 12, -16, 9, -16};
    drive(junk, 1'b0);
    for (int t = 0; t < 6; t++) begin
      check_int("R6 hold valid", int'(out_valid), 0);
      check_out("R6 hold data", VEC[NV-1]);
      @(negedge clk);
    end

    // R1: lone pulse timing
    drive(VEC[7], 1'b1);
    @(negedge clk);
    drive(junk, 1'b0);
    for (int t = 1; t <= 6; t++) begin
      check_int("R1 pulse valid", int'(out_valid), (t == 4) ? 1 : 0);
      if (t >= 4) check_out("R1 R6 pulse data", VEC[7]);
      @(negedge clk);
    end

    // R6: valid every other cycle, junk in gaps
    for (int t = 0; t < 16; t++) begin
      if (t >= 4 && ((t - 4) % 2 == 0)) begin
        check_int("R6 sparse valid", int'(out_valid), 1);
        check_out("R6 sparse data", VEC[((t - 4) / 2) + 2]);
      end
      if (t % 2 == 0 && t < 12) drive(VEC[(t / 2) + 2], 1'b1);
      else                     drive(junk, 1'b0);
      @(negedge clk);
    end

    // R7: reset with beats in flight
    last = VEC[4];
    drive(VEC[9], 1'b1);
    @(negedge clk);
    drive(last, 1'b1);
    @(negedge clk);
    #5 rst_n = 1'b0;
    #1;
    check_int("R7 async clear valid", int'(out_valid), 0);
    check_int("R7 async clear data", int'(out_re == '0 && out_im == '0), 1);
    drive(junk, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 5; t++) begin
      check_int("R7 flushed valid", int'(out_valid), 0);
      @(negedge clk);
    end

    // R4: single beat after reset
    drive(VEC[11], 1'b1);
    @(negedge clk);
    drive(junk, 1'b0);
    repeat (3) @(negedge clk);
    check_int("R1 post-reset valid", int'(out_valid), 1);
    check_out("R4 post-reset data", VEC[11]);

    finish_run();
  end
endmodule